// File: doc/BRIEF.md
# Word-Address Chip-Select Decoder

This block turns a 24-bit word address into active-low chip selects for five devices. These are a boot ROM, a working RAM, a second ROM and two small peripheral windows. An active-low address strobe qualifies every output. While the strobe is high, no device is selected, whatever the address bus carries. A separate active-high flag reports a strobed address that no device claims, so a bus-error path can be raised instead of returning junk.

A compile-time parameter picks one of two decoding schemes for the same device set:

- **Exact map.** Every upper address bit is compared, so each device answers at one window only.
- **Coarse map.** Only the top three or four address bits are compared. This needs far less logic, but every device repeats through a large aliased span. The whole upper half of the space stays empty.

Bit 0 of the address is never decoded. The word address (bits 23..1) goes straight out to the devices.

Top module: `chip_select_decoder`

## Requirements
- R1: With `EXACT_MAP=1` and `strobe_n` low, `sel_n[0]` (boot ROM) is low for addresses 0x000000 to 0x000FFF, including address 0, where the reset fetch starts.
- R2: With `EXACT_MAP=1` and `strobe_n` low, the following selects are low, each only inside its own range:
  - `sel_n[1]` (RAM) for 0x001000 to 0x001FFF.
  - `sel_n[2]` (second ROM) for 0x004000 to 0x007FFF.
  - `sel_n[3]` (peripheral A) for 0x008000 to 0x008003.
  - `sel_n[4]` (peripheral B) for 0x008004 to 0x008007.
- R3: With `EXACT_MAP=0` and `strobe_n` low, the following selects are low, and the remaining address bits do not matter:
  - `sel_n[0]` when bits 23..20 are 0000.
  - `sel_n[1]` when bits 23..20 are 0001.
  - `sel_n[2]` when bits 23..21 are 001.
  - `sel_n[3]` when bits 23..21 are 010.
  - `sel_n[4]` when bits 23..21 are 011.
- R4: With `EXACT_MAP=0` and `strobe_n` low, an address with bit 23 set leaves all selects high and drives `unclaimed` high. In this mode, `unclaimed` is high for no other address.
- R5: At no time is more than one bit of `sel_n` low.
- R6: Selects are active low. While `strobe_n` is high, `sel_n` is all ones and `unclaimed` is low.
- R7: With `EXACT_MAP=1` and `strobe_n` low, any address outside the five ranges of R1 and R2 leaves `sel_n` all ones and drives `unclaimed` high.
- R8: Address bit 0 has no effect on `sel_n` or `unclaimed`. `word_addr` always equals address bits 23..1, whether the strobe is active or not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 24 | Bus address; bit 0 is ignored |
| strobe_n | input | 1 | Active-low address strobe qualifying all selects |
| sel_n | output | 5 | Active-low selects: 0 boot ROM, 1 RAM, 2 second ROM, 3 peripheral A, 4 peripheral B |
| unclaimed | output | 1 | High when strobed and no device matches |
| word_addr | output | 23 | Address bits 23..1, passed straight to the devices |

## Verification
The block holds no state, so any fault in a window constant or a compare mask shows up in the same cycle as the address that exposes it. Such a fault appears at `sel_n` as a missing select, a select in a gap, two selects low together, or a wrong `unclaimed` flag. The vectors sit on both edges of every window and in every gap, and pseudo-random addresses cover both map variants side by side. This catches an off-by-one mask width at the first address past its window boundary.

// File: rtl/cs_map_pkg.sv
`timescale 1ns/1ps
package cs_map_pkg;

   localparam int MAP_AW   = 24;
   localparam int NUM_DEV  = 5;

   localparam int DEV_BOOT = 0;
   localparam int DEV_RAM  = 1;
   localparam int DEV_ROM2 = 2;
   localparam int DEV_PA   = 3;
   localparam int DEV_PB   = 4;

   typedef struct packed {
      logic [MAP_AW-1:0] base;
      logic [MAP_AW-1:0] care;
   } window_t;

   // Mask covering the top n address bits.
   function automatic logic [MAP_AW-1:0] top_bits(input int n);
      logic [MAP_AW-1:0] ones;
      ones = '1;
      return ones << (MAP_AW - n);
   endfunction

   // Exact map: every upper bit above each window compared.
   function automatic window_t exact_window(input int dev);
      window_t w;
      case (dev)
         DEV_BOOT: begin w.base = 24'h000000; w.care = top_bits(12); end
         DEV_RAM:  begin w.base = 24'h001000; w.care = top_bits(12); end
         DEV_ROM2: begin w.base = 24'h004000; w.care = top_bits(10); end
         DEV_PA:   begin w.base = 24'h008000; w.care = top_bits(22); end
         default:  begin w.base = 24'h008004; w.care = top_bits(22); end
      endcase
      return w;
   endfunction

   // Coarse map: only the top few bits, heavy aliasing.
   function automatic window_t coarse_window(input int dev);
      window_t w;
      case (dev)
         DEV_BOOT: begin w.base = 24'h000000; w.care = top_bits(4); end
         DEV_RAM:  begin w.base = 24'h100000; w.care = top_bits(4); end
         DEV_ROM2: begin w.base = 24'h200000; w.care = top_bits(3); end
         DEV_PA:   begin w.base = 24'h400000; w.care = top_bits(3); end
         default:  begin w.base = 24'h600000; w.care = top_bits(3); end
      endcase
      return w;
   endfunction

endpackage

// File: rtl/cs_window_match.sv
`timescale 1ns/1ps
module cs_window_match #(
   parameter int AW = 24
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] care,
   output logic          hit
);
   localparam logic [AW-1:0] WORD_MASK = {{(AW-1){1'b1}}, 1'b0};

   logic [AW-1:0] diff;

   always_comb begin
      diff = (addr ^ base) & care & WORD_MASK;
      hit  = (diff == '0);
   end
endmodule

// File: rtl/cs_match_array.sv
`timescale 1ns/1ps
module cs_match_array
   import cs_map_pkg::*;
#(
   parameter int AW        = MAP_AW,
   parameter int NDEV      = NUM_DEV,
   parameter bit EXACT_MAP = 1'b1
) (
   input  logic [AW-1:0]   addr,
   output logic [NDEV-1:0] hits
);
   if (EXACT_MAP) begin : g_exact
      for (genvar i = 0; i < NDEV; i++) begin : g_dev
         localparam window_t W = exact_window(i);
         cs_window_match #(.AW(AW)) u_m (
            .addr (addr),
            .base (W.base),
            .care (W.care),
            .hit  (hits[i])
         );
      end
   end else begin : g_coarse
      for (genvar i = 0; i < NDEV; i++) begin : g_dev
         localparam window_t W = coarse_window(i);
         cs_window_match #(.AW(AW)) u_m (
            .addr (addr),
            .base (W.base),
            .care (W.care),
            .hit  (hits[i])
         );
      end
   end
endmodule

// File: rtl/cs_output_stage.sv
`timescale 1ns/1ps
module cs_output_stage #(
   parameter int NDEV = 5
) (
   input  logic [NDEV-1:0] hits,
   input  logic            strobe_n,
   output logic [NDEV-1:0] sel_n,
   output logic            unclaimed
);
   always_comb begin
      sel_n     = strobe_n ? '1 : ~hits;
      unclaimed = !strobe_n && (hits == '0);
   end
endmodule

// File: rtl/chip_select_decoder.sv
`timescale 1ns/1ps
module chip_select_decoder
   import cs_map_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int NDEV      = 5,
   parameter bit EXACT_MAP = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              strobe_n,
   output logic [NDEV-1:0]   sel_n,
   output logic              unclaimed,
   output logic [ADDR_W-2:0] word_addr
);
   localparam int TOP = ADDR_W - 1;

   if (ADDR_W != MAP_AW) begin : g_bad_aw
      $error("chip_select_decoder: ADDR_W must match the map width");
   end
   if (NDEV != NUM_DEV) begin : g_bad_ndev
      $error("chip_select_decoder: NDEV must match the device count");
   end

   logic [NDEV-1:0] hits;

   cs_match_array #(.AW(ADDR_W), .NDEV(NDEV), .EXACT_MAP(EXACT_MAP)) u_match (
      .addr (addr),
      .hits (hits)
   );

   cs_output_stage #(.NDEV(NDEV)) u_out (
      .hits      (hits),
      .strobe_n  (strobe_n),
      .sel_n     (sel_n),
      .unclaimed (unclaimed)
   );

   assign word_addr = addr[ADDR_W-1:1];

   always_comb begin
      p_single_select_r5: assert ($onehot0(~sel_n))
         else $error("more than one select low");
      p_flag_excludes_sel_r7: assert (!unclaimed || (&sel_n))
         else $error("unclaimed with a select low");
      p_idle_strobe_r6: assert (!strobe_n || ((&sel_n) && !unclaimed))
         else $error("output active without strobe");
      p_boot_at_zero_r1: assert (strobe_n || (addr[TOP:1] != '0) || !sel_n[DEV_BOOT])
         else $error("address zero missed boot ROM");
      if (!EXACT_MAP) begin
         p_coarse_hole_r4: assert (strobe_n || (unclaimed == addr[TOP]))
            else $error("coarse map unclaimed flag wrong");
      end
   end
endmodule

// File: tb/sim_chip_select_decoder.sv
`timescale 1ns/1ps
module sim_chip_select_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] addr = '0;
   logic        strobe_n = 1'b1;
   logic [4:0]  sel_e, sel_c;
   logic        unc_e, unc_c;
   logic [22:0] wa_e, wa_c;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   chip_select_decoder #(.EXACT_MAP(1'b1)) u0 (
      .addr(addr), .strobe_n(strobe_n), .sel_n(sel_e),
      .unclaimed(unc_e), .word_addr(wa_e));

   chip_select_decoder #(.EXACT_MAP(1'b0)) u1 (
      .addr(addr), .strobe_n(strobe_n), .sel_n(sel_c),
      .unclaimed(unc_c), .word_addr(wa_c));

   typedef struct {
      logic [23:0] a;
      bit          exact;
      logic [4:0]  sel;
      logic        unc;
      string       tag;
   } item_t;

   item_t sb[$];

   // Reference map written as address ranges, independent of the RTL masks.
   function automatic int ref_dev(input bit exact, input logic [23:0] a);
      int v;
      v = int'({a[23:1], 1'b0});
      if (exact) begin
         if (v <= 'h000FFF) return 0;
         if (v >= 'h001000 && v <= 'h001FFF) return 1;
         if (v >= 'h004000 && v <= 'h007FFF) return 2;
         if (v >= 'h008000 && v <= 'h008003) return 3;
         if (v >= 'h008004 && v <= 'h008007) return 4;
         return -1;
      end
      if (v >= 'h800000) return -1;
      if (v < 'h100000) return 0;
      if (v < 'h200000) return 1;
      if (v < 'h400000) return 2;
      if (v < 'h600000) return 3;
      return 4;
   endfunction

   task automatic push(input bit exact, input logic [23:0] a, input logic s, input string tag);
      item_t it;
      int d;
      d = ref_dev(exact, a);
      it.a = a;
      it.exact = exact;
      it.tag = tag;
      it.sel = 5'b11111;
      it.unc = 1'b0;
      if (!s) begin
         if (d >= 0) it.sel[d] = 1'b0;
         else it.unc = 1'b1;
      end
      sb.push_back(it);
   endtask

   task automatic drive(input logic [23:0] a, input logic s, input string tag);
      @(negedge clk);
      addr = a;
      strobe_n = s;
      push(1'b1, a, s, tag);
      push(1'b0, a, s, tag);
   endtask

   // Monitor: compares at the posedge, half a period after inputs move.
   always @(posedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic [4:0]  gs;
         logic        gu;
         logic [22:0] gw;
         it = sb.pop_front();
         gs = it.exact ? sel_e : sel_c;
         gu = it.exact ? unc_e : unc_c;
         gw = it.exact ? wa_e : wa_c;
         checks++;
         if (gs !== it.sel || gu !== it.unc || gw !== it.a[23:1]) begin
            fails++;
            $display("FAIL %s %s addr=%h sel_n=%b unclaimed=%b word=%h expected sel_n=%b unclaimed=%b word=%h",
                     it.tag, it.exact ? "exact" : "coarse", it.a, gs, gu, gw,
                     it.sel, it.unc, it.a[23:1]);
         end
      end
   end

   initial begin
      logic [23:0] lfsr;
      repeat (3) @(posedge clk);
      // R6: reset state, strobe inactive.
      drive(24'h000000, 1'b1, "R6");
      rst_n = 1'b1;
      drive(24'h001000, 1'b1, "R6");
      drive(24'hFFFFFF, 1'b1, "R6");
      // R1: boot ROM window edges.
      drive(24'h000000, 1'b0, "R1");
      drive(24'h000FFE, 1'b0, "R1");
      drive(24'h000FFF, 1'b0, "R1");
      // R2: other exact windows, both edges.
      drive(24'h001000, 1'b0, "R2");
      drive(24'h001FFF, 1'b0, "R2");
      drive(24'h004000, 1'b0, "R2");
      drive(24'h007FFF, 1'b0, "R2");
      drive(24'h008000, 1'b0, "R2");
      drive(24'h008003, 1'b0, "R2");
      drive(24'h008004, 1'b0, "R2");
      drive(24'h008007, 1'b0, "R2");
      // R7: gaps of the exact map.
      drive(24'h002000, 1'b0, "R7");
      drive(24'h003FFE, 1'b0, "R7");
      drive(24'h008008, 1'b0, "R7");
      drive(24'h010000, 1'b0, "R7");
      drive(24'h0FFFFE, 1'b0, "R7");
      // R3: coarse windows and aliases.
      drive(24'h0FFFFE, 1'b0, "R3");
      drive(24'h100000, 1'b0, "R3");
      drive(24'h1ABCDE, 1'b0, "R3");
      drive(24'h200000, 1'b0, "R3");
      drive(24'h3FFFFF, 1'b0, "R3");
      drive(24'h400000, 1'b0, "R3");
      drive(24'h5FFFFE, 1'b0, "R3");
      drive(24'h600000, 1'b0, "R3");
      drive(24'h7FFFFF, 1'b0, "R3");
      // R4: upper half unclaimed in coarse map.
      drive(24'h800000, 1'b0, "R4");
      drive(24'h912345, 1'b0, "R4");
      drive(24'hFFFFFF, 1'b0, "R4");
      // R8: bit 0 toggles, word address passes with strobe high.
      drive(24'h008001, 1'b0, "R8");
      drive(24'h008005, 1'b0, "R8");
      drive(24'h001001, 1'b0, "R8");
      drive(24'h5A5A5B, 1'b1, "R8");
      // R5: pseudo-random addresses, strobe mostly active.
      lfsr = 24'hACE1F3;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
         if (i % 4 == 1) drive({9'h000, lfsr[14:0]}, lfsr[20] & lfsr[19], "R5");
         else drive(lfsr, lfsr[20] & lfsr[19], "R5");
      end
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(100000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired after %0d checks, expected completion", checks);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule